// File: doc/BRIEF.md
# Descriptor Ring Fetch and Write-Back Engine

This block walks a circular ring of 16-byte transfer descriptors kept in host memory. Once started, it reads each descriptor one 32-bit word at a time and checks that hardware owns it. It passes the source, destination and byte count to an external data mover. When the mover reports back, it hands the descriptor back to software by rewriting the descriptor's first word in place with a completion status. The walk continues around the ring until a descriptor that hardware does not own is found. The block then stops and raises an invalid-descriptor status.

A small write-only register port sets up the ring: a 64-bit base split across two words, the next-descriptor pointer, the entry count, a fetch-ahead limit and a control word. A word-wide memory port carries read and write requests, each with a valid/ready handshake and at most one transaction in flight on each channel. Two sticky status bits report completion of descriptors that asked for an interrupt, and the stop on a software-owned entry. Both bits are cleared by writing ones.

Top module: `dring_engine`

## Requirements
- R1: After reset the block is not busy. No read, write or mover request is asserted, both status bits are 0, and the next-descriptor pointer is 0.
- R2: Register offsets are 0 base low, 1 base high, 2 next pointer, 3 entry count, 4 fetch-ahead limit, 5 control and 6 status. Writing base low also loads the next pointer with that value. A control write with bit 0 set starts the walk. Control bit 1 is a stored write-back enable.
- R3: Each descriptor is fetched as four word reads at next+0, +4, +8 and +12. The upper 32 address bits of each read come from base high, and a new read is not issued before the previous one has returned. The words are as follows. Word 0 holds the flags: bit 31 means hardware-owned, bit 30 requests an interrupt, and bits 26:0 hold the length. Word 1 holds the destination high half in bits 15:0 and the source high half in bits 31:16. Word 2 is the destination low half and word 3 is the source low half. The mover receives the 48-bit source, the 48-bit destination and the length.
- R4: A fetched word 0 with bit 31 clear stops the walk and sets status bit 1. No mover request is made for that entry, its other words are not read, and the next pointer keeps pointing at it.
- R5: The write-back word is written to the descriptor's word 0 address. Bit 31 is 0. Bit 30 is set when neither failure is reported. Bit 29 is the read failure and bit 28 is the write failure. Bit 27 is 0, and bits 26:0 hold the byte count reported by the mover.
- R6: The write-back is issued only while control bit 1 is set. With it clear, memory is never written.
- R7: After each descriptor is fetched, the next pointer advances by 16. After the entry at base + 16*(count-1), it returns to base low.
- R8: The number of descriptors fetched but not yet completed never exceeds the limit. A limit of 0 counts as 1, and the limit is capped at the queue depth. A descriptor completes when its write-back is accepted, or when the mover responds if write-back is off. With a limit of 1, the next fetch starts only after the previous descriptor completes.
- R9: Completing a descriptor whose word 0 bit 30 was set raises status bit 2. Writing a status word with bit 1 or bit 2 set clears the matching bit.
- R10: A read or write request held without ready keeps its valid, address and data stable until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register offset |
| cfg_wdata | input | 32 | Register write data |
| rd_req_valid | output | 1 | Memory read request valid |
| rd_req_ready | input | 1 | Memory read request accepted |
| rd_req_addr | output | 64 | Memory read byte address |
| rd_rsp_valid | input | 1 | Read data valid |
| rd_rsp_data | input | 32 | Read data |
| wr_req_valid | output | 1 | Memory write request valid |
| wr_req_ready | input | 1 | Memory write accepted |
| wr_req_addr | output | 64 | Memory write byte address |
| wr_req_data | output | 32 | Memory write data |
| mv_valid | output | 1 | Transfer request to the data mover |
| mv_ready | input | 1 | Mover accepts the request |
| mv_src | output | 48 | Transfer source address |
| mv_dst | output | 48 | Transfer destination address |
| mv_len | output | 27 | Transfer length in bytes |
| mv_done | input | 1 | Mover completion strobe |
| mv_bytes | input | 27 | Bytes actually moved |
| mv_rd_err | input | 1 | Mover read failure |
| mv_wr_err | input | 1 | Mover write failure |
| nxt_addr | output | 32 | Next-descriptor pointer |
| st_inv | output | 1 | Sticky stop-on-software-owned status |
| st_done | output | 1 | Sticky interrupt-requested completion status |
| busy | output | 1 | Walk or drain in progress |

## Verification
The bench ends a walk on a software-owned entry placed just past the valid ones. A design that ignored the ownership bit would issue an extra mover request, and one that advanced past that entry would leave the pointer one slot too far. A second walk crosses the end of the ring, so a wrong wrap shows up as a fetch from the wrong address and a wrong final pointer. Mover responses carry short counts and read or write failures, and each written-back word is compared bit by bit. Swapped flag positions or a stale size field therefore show as a mismatch. A slow mover combined with stalled memory ready measures how far the engine fetches ahead against limits of 1 and 3. A run with write-back disabled must leave memory untouched while still setting the completion status.

// File: rtl/dring_pkg.sv
package dring_pkg;

  localparam int unsigned LEN_W = 27;
  localparam int unsigned DESC_BYTES = 16;

  typedef struct packed {
    logic [31:0]      addr;
    logic             irq;
    logic [LEN_W-1:0] len;
    logic [47:0]      src;
    logic [47:0]      dst;
  } desc_t;

  // pointer after the current entry, wrapping after count entries
  function automatic logic [31:0] ring_step(logic [31:0] cur, logic [31:0] base,
                                            logic [31:0] cnt);
    logic [31:0] nx;
    logic [31:0] lim;
    nx  = cur + 32'(DESC_BYTES);
    lim = base + (cnt << 4);
    return (nx >= lim) ? base : nx;
  endfunction

  // completion word written over word 0
  function automatic logic [31:0] wb_word(logic [LEN_W-1:0] bytes, logic rd_err,
                                          logic wr_err);
    return {1'b0, ~(rd_err | wr_err), rd_err, wr_err, 1'b0, bytes};
  endfunction

  // effective fetch-ahead bound: zero acts as one, capped at depth
  function automatic logic [31:0] eff_limit(logic [7:0] lim, logic [31:0] depth);
    logic [31:0] l;
    l = (lim == 8'd0) ? 32'd1 : {24'd0, lim};
    return (l > depth) ? depth : l;
  endfunction

endpackage

// File: rtl/dring_ptr.sv
module dring_ptr #(
  parameter int CNT_W = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [2:0]  cfg_addr,
  input  logic [31:0] cfg_wdata,
  input  logic        adv,
  output logic [31:0] base_lo,
  output logic [31:0] base_hi,
  output logic [31:0] nxt,
  output logic [7:0]  plim,
  output logic        wb_en,
  output logic        go,
  output logic [1:0]  clr
);
  import dring_pkg::*;

  logic [CNT_W-1:0] cnt_q;

  assign go  = cfg_we && (cfg_addr == 3'd5) && cfg_wdata[0];
  assign clr = (cfg_we && (cfg_addr == 3'd6)) ? cfg_wdata[2:1] : 2'b00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_lo <= '0;
      base_hi <= '0;
      nxt     <= '0;
      cnt_q   <= '0;
      plim    <= '0;
      wb_en   <= 1'b0;
    end else begin
      if (adv) nxt <= ring_step(nxt, base_lo, 32'(cnt_q));
      if (cfg_we) begin
        case (cfg_addr)
          3'd0: begin base_lo <= cfg_wdata; nxt <= cfg_wdata; end
          3'd1: base_hi <= cfg_wdata;
          3'd2: nxt <= cfg_wdata;
          3'd3: cnt_q <= cfg_wdata[CNT_W-1:0];
          3'd4: plim <= cfg_wdata[7:0];
          3'd5: wb_en <= cfg_wdata[1];
          default: ;
        endcase
      end
    end
  end

  // R7
  adv_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !cfg_we) |=> (nxt == base_lo) || (nxt == $past(nxt) + 32'd16));

endmodule

// File: rtl/dring_fetch.sv
module dring_fetch (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               go,
  input  logic               room,
  input  logic [31:0]        nxt,
  input  logic [31:0]        base_hi,
  output logic               rd_req_valid,
  input  logic               rd_req_ready,
  output logic [63:0]        rd_req_addr,
  input  logic               rd_rsp_valid,
  input  logic [31:0]        rd_rsp_data,
  output logic               push,
  output dring_pkg::desc_t   push_d,
  output logic               inv_evt,
  output logic               active
);
  import dring_pkg::*;

  typedef enum logic [1:0] {F_IDLE, F_REQ, F_WAIT} fst_t;
  fst_t st;
  logic             run_q;
  logic [1:0]       wix;
  logic [31:0]      fa;
  logic             irq_q;
  logic [LEN_W-1:0] len_q;
  logic [31:0]      w1_q, w2_q;
  logic             rsp_take;

  assign rsp_take     = (st == F_WAIT) && rd_rsp_valid;
  assign inv_evt      = rsp_take && (wix == 2'd0) && !rd_rsp_data[31];
  assign push         = rsp_take && (wix == 2'd3);
  assign rd_req_valid = (st == F_REQ);
  assign rd_req_addr  = {base_hi, fa + {28'd0, wix, 2'b00}};
  assign active       = run_q || (st != F_IDLE);

  always_comb begin
    push_d.addr = fa;
    push_d.irq  = irq_q;
    push_d.len  = len_q;
    push_d.dst  = {w1_q[15:0], w2_q};
    push_d.src  = {w1_q[31:16], rd_rsp_data};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= F_IDLE;
      run_q <= 1'b0;
      wix   <= '0;
      fa    <= '0;
      irq_q <= 1'b0;
      len_q <= '0;
      w1_q  <= '0;
      w2_q  <= '0;
    end else begin
      case (st)
        F_IDLE: if (run_q && room) begin
          st  <= F_REQ;
          wix <= 2'd0;
          fa  <= nxt;
        end
        F_REQ: if (rd_req_ready) st <= F_WAIT;
        F_WAIT: if (rd_rsp_valid) begin
          case (wix)
            2'd0: begin
              if (!rd_rsp_data[31]) begin
                run_q <= 1'b0;
                st    <= F_IDLE;
              end else begin
                irq_q <= rd_rsp_data[30];
                len_q <= rd_rsp_data[LEN_W-1:0];
                wix   <= 2'd1;
                st    <= F_REQ;
              end
            end
            2'd1: begin w1_q <= rd_rsp_data; wix <= 2'd2; st <= F_REQ; end
            2'd2: begin w2_q <= rd_rsp_data; wix <= 2'd3; st <= F_REQ; end
            default: begin wix <= 2'd0; st <= F_IDLE; end
          endcase
        end
        default: st <= F_IDLE;
      endcase
      if (go) run_q <= 1'b1;
    end
  end

  // R4
  inv_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_evt && !go) |=> !active);

  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && !rd_req_ready) |=> rd_req_valid && $stable(rd_req_addr));

endmodule

// File: rtl/dring_queue.sv
module dring_queue #(
  parameter int DEPTH = 4,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  dring_pkg::desc_t push_d,
  input  logic             pop,
  output dring_pkg::desc_t head,
  output logic             empty,
  output logic [CW-1:0]    cnt
);
  import dring_pkg::*;

  desc_t         slot [DEPTH];
  logic [AW-1:0] wp, rp;

  function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
    return (32'(p) == DEPTH - 1) ? '0 : p + 1'b1;
  endfunction

  assign head  = slot[rp];
  assign empty = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= bump(wp);
      if (pop)  rp <= bump(rp);
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (push && (32'(wp) == g)) slot[g] <= push_d;
    end
  end

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (32'(cnt) < DEPTH) || pop);

endmodule

// File: rtl/dring_exec.sv
module dring_exec (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        q_empty,
  input  dring_pkg::desc_t            q_head,
  input  logic                        wb_en,
  input  logic [31:0]                 base_hi,
  input  logic [1:0]                  clr,
  input  logic                        inv_evt,
  output logic                        mv_valid,
  input  logic                        mv_ready,
  output logic [47:0]                 mv_src,
  output logic [47:0]                 mv_dst,
  output logic [dring_pkg::LEN_W-1:0] mv_len,
  input  logic                        mv_done,
  input  logic [dring_pkg::LEN_W-1:0] mv_bytes,
  input  logic                        mv_rd_err,
  input  logic                        mv_wr_err,
  output logic                        wr_req_valid,
  input  logic                        wr_req_ready,
  output logic [63:0]                 wr_req_addr,
  output logic [31:0]                 wr_req_data,
  output logic                        pop,
  output logic                        st_inv,
  output logic                        st_done,
  output logic                        active
);
  import dring_pkg::*;

  typedef enum logic [1:0] {E_IDLE, E_MV, E_RSP, E_WB} est_t;
  est_t        st;
  logic [31:0] wbd;

  assign mv_valid     = (st == E_MV);
  assign mv_src       = q_head.src;
  assign mv_dst       = q_head.dst;
  assign mv_len       = q_head.len;
  assign wr_req_valid = (st == E_WB);
  assign wr_req_addr  = {base_hi, q_head.addr};
  assign wr_req_data  = wbd;
  assign pop          = ((st == E_RSP) && mv_done && !wb_en) ||
                        ((st == E_WB) && wr_req_ready);
  assign active       = (st != E_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= E_IDLE;
      wbd     <= '0;
      st_inv  <= 1'b0;
      st_done <= 1'b0;
    end else begin
      case (st)
        E_IDLE: if (!q_empty) st <= E_MV;
        E_MV:   if (mv_ready) st <= E_RSP;
        E_RSP:  if (mv_done) begin
          wbd <= wb_word(mv_bytes, mv_rd_err, mv_wr_err);
          st  <= wb_en ? E_WB : E_IDLE;
        end
        E_WB:   if (wr_req_ready) st <= E_IDLE;
        default: st <= E_IDLE;
      endcase
      st_inv  <= inv_evt | (st_inv & ~clr[0]);
      st_done <= (pop & q_head.irq) | (st_done & ~clr[1]);
    end
  end

  // R9
  done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && q_head.irq) |=> st_done);

  // R10
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req_valid && !wr_req_ready) |=>
      wr_req_valid && $stable(wr_req_addr) && $stable(wr_req_data));

endmodule

// File: rtl/dring_engine.sv
module dring_engine #(
  parameter int DEPTH = 4,
  parameter int CNT_W = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [2:0]  cfg_addr,
  input  logic [31:0] cfg_wdata,
  output logic        rd_req_valid,
  input  logic        rd_req_ready,
  output logic [63:0] rd_req_addr,
  input  logic        rd_rsp_valid,
  input  logic [31:0] rd_rsp_data,
  output logic        wr_req_valid,
  input  logic        wr_req_ready,
  output logic [63:0] wr_req_addr,
  output logic [31:0] wr_req_data,
  output logic        mv_valid,
  input  logic        mv_ready,
  output logic [47:0] mv_src,
  output logic [47:0] mv_dst,
  output logic [26:0] mv_len,
  input  logic        mv_done,
  input  logic [26:0] mv_bytes,
  input  logic        mv_rd_err,
  input  logic        mv_wr_err,
  output logic [31:0] nxt_addr,
  output logic        st_inv,
  output logic        st_done,
  output logic        busy
);
  import dring_pkg::*;

  logic [31:0] base_lo, base_hi;
  logic [7:0]  plim;
  logic        wb_en, go, adv, push, pop, inv_evt, room;
  logic        q_empty, f_active, e_active;
  logic [1:0]  clr;
  logic [CW-1:0] q_cnt;
  desc_t       push_d, q_head;

  assign room = (32'(q_cnt) < eff_limit(plim, 32'(DEPTH)));
  assign busy = f_active | e_active | !q_empty;

  dring_ptr #(.CNT_W(CNT_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .adv(adv), .base_lo(base_lo), .base_hi(base_hi),
    .nxt(nxt_addr), .plim(plim), .wb_en(wb_en), .go(go), .clr(clr)
  );

  dring_fetch u_fetch (
    .clk(clk), .rst_n(rst_n), .go(go), .room(room), .nxt(nxt_addr),
    .base_hi(base_hi), .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
    .rd_req_addr(rd_req_addr), .rd_rsp_valid(rd_rsp_valid),
    .rd_rsp_data(rd_rsp_data), .push(push), .push_d(push_d),
    .inv_evt(inv_evt), .active(f_active)
  );

  assign adv = push;

  dring_queue #(.DEPTH(DEPTH)) u_queue (
    .clk(clk), .rst_n(rst_n), .push(push), .push_d(push_d), .pop(pop),
    .head(q_head), .empty(q_empty), .cnt(q_cnt)
  );

  dring_exec u_exec (
    .clk(clk), .rst_n(rst_n), .q_empty(q_empty), .q_head(q_head),
    .wb_en(wb_en), .base_hi(base_hi), .clr(clr), .inv_evt(inv_evt),
    .mv_valid(mv_valid), .mv_ready(mv_ready), .mv_src(mv_src),
    .mv_dst(mv_dst), .mv_len(mv_len), .mv_done(mv_done),
    .mv_bytes(mv_bytes), .mv_rd_err(mv_rd_err), .mv_wr_err(mv_wr_err),
    .wr_req_valid(wr_req_valid), .wr_req_ready(wr_req_ready),
    .wr_req_addr(wr_req_addr), .wr_req_data(wr_req_data), .pop(pop),
    .st_inv(st_inv), .st_done(st_done), .active(e_active)
  );

endmodule

// File: tb/test_dring_engine.sv
`timescale 1ns/1ps
module test_dring_engine;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        rd_req_valid, rd_req_ready;
  logic [63:0] rd_req_addr;
  logic        rd_rsp_valid;
  logic [31:0] rd_rsp_data;
  logic        wr_req_valid, wr_req_ready;
  logic [63:0] wr_req_addr;
  logic [31:0] wr_req_data;
  logic        mv_valid, mv_ready;
  logic [47:0] mv_src, mv_dst;
  logic [26:0] mv_len;
  logic        mv_done;
  logic [26:0] mv_bytes;
  logic        mv_rd_err, mv_wr_err;
  logic [31:0] nxt_addr;
  logic        st_inv, st_done, busy;

  always #2.5 clk = ~clk;

  dring_engine i_dring_engine (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .rd_req_valid(rd_req_valid),
    .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
    .wr_req_valid(wr_req_valid), .wr_req_ready(wr_req_ready),
    .wr_req_addr(wr_req_addr), .wr_req_data(wr_req_data),
    .mv_valid(mv_valid), .mv_ready(mv_ready), .mv_src(mv_src),
    .mv_dst(mv_dst), .mv_len(mv_len), .mv_done(mv_done),
    .mv_bytes(mv_bytes), .mv_rd_err(mv_rd_err), .mv_wr_err(mv_wr_err),
    .nxt_addr(nxt_addr), .st_inv(st_inv), .st_done(st_done), .busy(busy)
  );

  typedef struct {
    logic [47:0] src, dst;
    logic [26:0] len, bytes;
    logic        rd, wr;
  } mv_item_t;
  typedef struct {
    logic [31:0] addr, data;
  } wb_item_t;

  mv_item_t exp_mv[$];
  wb_item_t exp_wb[$];
  logic [31:0] mem [256];

  int total = 0, fails = 0;
  int stall = 0, mv_dly = 3;
  int fetched = 0, completed = 0, max_ahead = 0;
  logic [31:0] ring_base = 32'h100;
  logic [31:0] hi_addr = 32'h5;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] done_word(logic [26:0] b, logic rd, logic wr);
    logic [31:0] w;
    w = 32'd0;
    w[26:0] = b;
    w[28] = wr;
    w[29] = rd;
    w[30] = !(rd || wr);
    return w;
  endfunction

  function automatic int widx(logic [31:0] a);
    return int'((a >> 2) & 32'hff);
  endfunction

  // driver: lays a descriptor in memory and queues what it should produce
  task automatic put_desc(int slot, logic own, logic irq, logic [26:0] len,
                          logic [47:0] src, logic [47:0] dst, logic [26:0] bytes,
                          logic rd, logic wr, logic wb);
    logic [31:0] a;
    mv_item_t m;
    wb_item_t w;
    a = ring_base + 32'(slot * 16);
    mem[widx(a)]      = {own, irq, 3'b000, len};
    mem[widx(a) + 1]  = {src[47:32], dst[47:32]};
    mem[widx(a) + 2]  = dst[31:0];
    mem[widx(a) + 3]  = src[31:0];
    if (own) begin
      m.src = src; m.dst = dst; m.len = len; m.bytes = bytes; m.rd = rd; m.wr = wr;
      exp_mv.push_back(m);
      if (wb) begin
        w.addr = a; w.data = done_word(bytes, rd, wr);
        exp_wb.push_back(w);
      end
    end
  endtask

  task automatic cfg_wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic run_wait(string req);
    int n;
    repeat (3) @(negedge clk);
    n = 0;
    while (busy && n < 20000) begin
      @(negedge clk);
      n++;
    end
    total++;
    if (busy) begin
      fails++;
      $display("FAIL %s actual=busy expected=idle", req);
    end
    chk({req, " mover items left"}, 64'(exp_mv.size()), 0);
    chk({req, " write-backs left"}, 64'(exp_wb.size()), 0);
  endtask

  // monitor: memory and mover models, scoreboard pops
  initial begin
    int cyc;
    logic rd_pend;
    int rd_pa;
    int cd;
    mv_item_t cur;
    cyc = 0; rd_pend = 1'b0; rd_pa = 0; cd = 0;
    rd_req_ready = 1'b0; rd_rsp_valid = 1'b0; rd_rsp_data = '0;
    wr_req_ready = 1'b0; mv_ready = 1'b1; mv_done = 1'b0;
    mv_bytes = '0; mv_rd_err = 1'b0; mv_wr_err = 1'b0;
    forever begin
      @(negedge clk);
      cyc++;
      rd_rsp_valid = rd_pend;
      rd_rsp_data  = mem[rd_pa];
      rd_pend      = 1'b0;
      rd_req_ready = (stall != 0) ? (cyc % 3 == 0) : 1'b1;
      if (rd_req_valid && rd_req_ready) begin
        chk("R3 read high address", 64'(rd_req_addr[63:32]), 64'(hi_addr));
        rd_pend = 1'b1;
        rd_pa = widx(rd_req_addr[31:0]);
        if (rd_req_addr[3:0] == 4'd0) fetched++;
        if (fetched - completed > max_ahead) max_ahead = fetched - completed;
      end
      wr_req_ready = (stall != 0) ? (cyc % 2 == 0) : 1'b1;
      if (wr_req_valid && wr_req_ready) begin
        if (exp_wb.size() == 0) begin
          chk("R6 unexpected write-back", wr_req_addr, 64'd0);
        end else begin
          wb_item_t w;
          w = exp_wb.pop_front();
          chk("R5 write-back address", wr_req_addr, {hi_addr, w.addr});
          chk("R5 write-back word", 64'(wr_req_data), 64'(w.data));
        end
        mem[widx(wr_req_addr[31:0])] = wr_req_data;
        completed++;
      end
      mv_done = 1'b0;
      if (cd > 0) begin
        cd--;
        if (cd == 0) begin
          mv_done = 1'b1; mv_bytes = cur.bytes;
          mv_rd_err = cur.rd; mv_wr_err = cur.wr;
        end
      end
      if (mv_valid) begin
        if (exp_mv.size() == 0) begin
          chk("R4 unexpected mover request", {16'd0, mv_src}, 64'd0);
        end else begin
          cur = exp_mv.pop_front();
          chk("R3 mover source", {16'd0, mv_src}, {16'd0, cur.src});
          chk("R3 mover destination", {16'd0, mv_dst}, {16'd0, cur.dst});
          chk("R3 mover length", 64'(mv_len), 64'(cur.len));
        end
        cd = mv_dly;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [31:0] saved;
    for (int i = 0; i < 256; i++) mem[i] = 32'd0;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 busy", 64'(busy), 0);
    chk("R1 next pointer", 64'(nxt_addr), 0);
    chk("R1 status", {62'd0, st_done, st_inv}, 0);
    chk("R1 requests", {61'd0, rd_req_valid, wr_req_valid, mv_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 setup; base write loads next pointer
    cfg_wr(3'd0, ring_base);
    cfg_wr(3'd1, hi_addr);
    cfg_wr(3'd3, 32'd4);
    cfg_wr(3'd4, 32'd1);
    chk("R2 base loads next", 64'(nxt_addr), 64'(ring_base));

    // Run A: three owned entries, errors, short count, stop on slot 3
    put_desc(0, 1, 0, 27'd64, 48'h1111_0000_1000, 48'h2222_0000_2000, 27'd64, 0, 0, 1);
    put_desc(1, 1, 1, 27'd100, 48'h0001_0000_3000, 48'h0002_0000_4000, 27'd40, 1, 0, 1);
    put_desc(2, 1, 0, 27'd8, 48'h00aa_1234_5678, 48'h00bb_8765_4321, 27'd8, 0, 1, 1);
    put_desc(3, 0, 0, 27'd4, 48'h0, 48'h0, 27'd0, 0, 0, 1);
    fetched = 0; completed = 0; max_ahead = 0;
    cfg_wr(3'd5, 32'h3);
    run_wait("R3 run A");
    chk("R4 stop pointer", 64'(nxt_addr), 64'(ring_base + 32'h30));
    chk("R4 invalid status", 64'(st_inv), 1);
    chk("R9 done status", 64'(st_done), 1);
    chk("R5 memory word0", 64'(mem[widx(ring_base)]), 64'h4000_0040);
    chk("R8 limit one ahead", 64'(max_ahead), 1);

    cfg_wr(3'd6, 32'h6);
    chk("R9 status clear", {62'd0, st_done, st_inv}, 0);

    // Run B: wrap from slot 3 to slot 0, stop at slot 1
    put_desc(3, 1, 0, 27'd16, 48'h0003_0000_0300, 48'h0004_0000_0400, 27'd16, 0, 0, 1);
    put_desc(0, 1, 0, 27'd32, 48'h0005_0000_0500, 48'h0006_0000_0600, 27'd32, 0, 0, 1);
    cfg_wr(3'd5, 32'h3);
    run_wait("R7 run B");
    chk("R7 wrapped pointer", 64'(nxt_addr), 64'(ring_base + 32'h10));
    chk("R9 no irq no done", 64'(st_done), 0);
    chk("R4 invalid after wrap", 64'(st_inv), 1);
    cfg_wr(3'd6, 32'h6);

    // Run C: write-back disabled
    put_desc(1, 1, 1, 27'd12, 48'h0007_0000_0700, 48'h0008_0000_0800, 27'd12, 0, 0, 0);
    saved = mem[widx(ring_base + 32'h10)];
    cfg_wr(3'd5, 32'h1);
    run_wait("R6 run C");
    chk("R6 memory untouched", 64'(mem[widx(ring_base + 32'h10)]), 64'(saved));
    chk("R9 done without write-back", 64'(st_done), 1);
    chk("R7 pointer after C", 64'(nxt_addr), 64'(ring_base + 32'h20));
    cfg_wr(3'd6, 32'h6);

    // Run D: fetch-ahead of 3 with slow mover and stalled memory
    cfg_wr(3'd3, 32'd8);
    cfg_wr(3'd0, ring_base);
    cfg_wr(3'd4, 32'd3);
    stall = 1; mv_dly = 20;
    for (int s = 0; s < 6; s++)
      put_desc(s, 1, 0, 27'(s * 8 + 4), 48'(s * 256 + 48'h10_0000),
               48'(s * 256 + 48'h20_0000), 27'(s * 8 + 4), 0, 0, 1);
    put_desc(6, 0, 0, 27'd0, 48'h0, 48'h0, 27'd0, 0, 0, 1);
    fetched = 0; completed = 0; max_ahead = 0;
    cfg_wr(3'd5, 32'h3);
    run_wait("R10 run D");
    chk("R8 limit three ahead", 64'(max_ahead), 3);
    chk("R7 pointer after D", 64'(nxt_addr), 64'(ring_base + 32'h60));
    chk("R10 last write-back", 64'(mem[widx(ring_base + 32'h50)]), 64'h4000_002c);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule